// File: doc/BRIEF.md
# Delay Code Margin Trim Counter

This block sits between a delay-locked loop and a delayed-clock element. The loop supplies an 8-bit base delay code. The block adds a signed margin offset to that code and drives the trimmed result to the delay element. With a zero offset the trimmed code equals the base code, which gives the nominal quarter-period (90°) delay.

Software or a training engine moves the offset one step at a time. It raises a move strobe and then lowers it. The direction input is sampled when the strobe falls. An active-low load input puts the offset back to zero. A limit flag shows that the offset has reached the end of its range in the direction of the most recent move. All inputs belong to one system clock domain.

The offset is a 7-bit signed value, −64 to +63. The trimmed code is the base code plus the offset, held inside 0..255.

Top module: `dly_trim_top`

## Requirements
- R1: While reset is asserted and right after it is released, the offset is zero, so `trim_code` equals `base_code` and `lim_flag` is 0.
- R2: When `load_n` is 0 at a rising clock edge, the offset becomes zero and `lim_flag` becomes 0. From the next cycle on, `trim_code` equals `base_code`.
- R3: Each falling edge of `move` changes the offset by exactly one step. The falling edge is `move` seen as 1 at one rising clock edge and as 0 at the next. The step takes effect at the second of those edges. Holding `move` steady at 1 or at 0 leaves the offset unchanged.
- R4: `dir_dn` is sampled in the same cycle that the falling edge of `move` is detected. Its value while `move` is high has no effect. `dir_dn` = 1 lowers the offset by one (less delay). `dir_dn` = 0 raises it by one (more delay).
- R5: The offset saturates at +63 and at −64. A move past either limit leaves it unchanged.
- R6: `lim_flag` goes to 1 when an upward move leaves the offset at +63, or a downward move leaves it at −64. It stays 1 through further moves in the same direction. It clears on a move in the opposite direction.
- R7: `trim_code` is `base_code` plus the signed offset, clamped to 0..255. It follows `base_code` in the same cycle, with no register between them.
- R8: If a load and a detected falling edge of `move` fall in the same cycle, the load wins: the offset becomes zero and `lim_flag` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_code | input | 8 | Base delay code from the DLL |
| load_n | input | 1 | Active-low return of the offset to zero |
| move | input | 1 | Step strobe; one step per falling edge |
| dir_dn | input | 1 | Step direction: 1 = less delay, 0 = more delay |
| trim_code | output | 8 | Base code plus offset, clamped |
| lim_flag | output | 1 | Offset has reached the limit in the last move direction |

## Verification
The assertions assume that `move` and `dir_dn` are synchronous to `clk` and hold steady between edges. They also assume that `move` stays high for at least one rising edge, so that each strobe produces a single detected edge. The stimulus changes every input only on the falling clock edge, and it keeps each strobe high for a full cycle. While the strobe is high, the bench drives the wrong direction on purpose, and it puts the real direction on only when the strobe falls. Offset sweeps run with a base code of 128, so the raw offset can be read at `trim_code` without clamping. Separate full sweeps of the base code at both offset limits exercise the clamp.

// File: rtl/dly_trim_pkg.sv
package dly_trim_pkg;

   typedef enum logic {
      STEP_UP = 1'b0,
      STEP_DN = 1'b1
   } step_dir_e;

   typedef struct packed {
      logic      valid;
      step_dir_e dir;
   } step_req_t;

endpackage

// File: rtl/dly_trim_edge.sv
module dly_trim_edge
   import dly_trim_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      move,
   input  logic      dir_dn,
   output step_req_t req
);

   logic move_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) move_q <= 1'b0;
      else        move_q <= move;
   end

   always_comb begin
      req.valid = move_q & ~move;
      req.dir   = step_dir_e'(dir_dn);
   end

   // R3
   step_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req.valid |=> !req.valid);

endmodule

// File: rtl/dly_trim_offset.sv
module dly_trim_offset
   import dly_trim_pkg::*;
#(
   parameter int OFS_W = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_n,
   input  step_req_t               req,
   output logic signed [OFS_W-1:0] ofs,
   output logic                    flag
);

   localparam logic signed [OFS_W-1:0] OFS_MAX = {1'b0, {(OFS_W-1){1'b1}}};
   localparam logic signed [OFS_W-1:0] OFS_MIN = {1'b1, {(OFS_W-1){1'b0}}};
   localparam logic signed [OFS_W-1:0] ONE     = OFS_W'(1);

   logic signed [OFS_W-1:0] ofs_nxt;
   logic                    flag_nxt;

   always_comb begin
      ofs_nxt  = ofs;
      flag_nxt = flag;
      if (req.valid) begin
         if (req.dir == STEP_UP) begin
            ofs_nxt  = (ofs == OFS_MAX) ? ofs : ofs + ONE;
            flag_nxt = (ofs_nxt == OFS_MAX);
         end else begin
            ofs_nxt  = (ofs == OFS_MIN) ? ofs : ofs - ONE;
            flag_nxt = (ofs_nxt == OFS_MIN);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs  <= '0;
         flag <= 1'b0;
      end else if (!load_n) begin
         ofs  <= '0;
         flag <= 1'b0;
      end else begin
         ofs  <= ofs_nxt;
         flag <= flag_nxt;
      end
   end

   // R2
   load_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> (ofs == '0) && !flag);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !req.valid) |=> $stable(ofs) && $stable(flag));

   // R4
   up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && req.valid && req.dir == STEP_UP && ofs != OFS_MAX)
      |=> ofs == $past(ofs) + ONE);

   // R4
   dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && req.valid && req.dir == STEP_DN && ofs != OFS_MIN)
      |=> ofs == $past(ofs) - ONE);

   // R5
   no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && ofs == OFS_MAX) |=> ofs != OFS_MIN);

   // R5
   no_wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && ofs == OFS_MIN) |=> ofs != OFS_MAX);

   // R6
   flag_at_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag |-> (ofs == OFS_MAX) || (ofs == OFS_MIN));

endmodule

// File: rtl/dly_trim_sum.sv
module dly_trim_sum #(
   parameter int CODE_W = 8,
   parameter int OFS_W  = 7
) (
   input  logic [CODE_W-1:0]       base,
   input  logic signed [OFS_W-1:0] ofs,
   output logic [CODE_W-1:0]       code
);

   localparam int SUM_W = CODE_W + 2;
   localparam logic signed [SUM_W-1:0] CODE_TOP = SUM_W'((1 << CODE_W) - 1);

   logic signed [SUM_W-1:0] base_x;
   logic signed [SUM_W-1:0] ofs_x;
   logic signed [SUM_W-1:0] sum;

   always_comb begin
      base_x = signed'({2'b00, base});
      ofs_x  = SUM_W'(ofs);
      sum    = base_x + ofs_x;
      if (sum < 0)             code = '0;
      else if (sum > CODE_TOP) code = CODE_TOP[CODE_W-1:0];
      else                     code = sum[CODE_W-1:0];
   end

endmodule

// File: rtl/dly_trim_top.sv
module dly_trim_top
   import dly_trim_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int OFS_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] base_code,
   input  logic              load_n,
   input  logic              move,
   input  logic              dir_dn,
   output logic [CODE_W-1:0] trim_code,
   output logic              lim_flag
);

   generate
      if (OFS_W < 2 || OFS_W > CODE_W) begin : g_bad_ofs_w
         $error("dly_trim_top: OFS_W must be in 2..CODE_W");
      end
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code_w
         $error("dly_trim_top: CODE_W must be in 2..16");
      end
   endgenerate

   step_req_t               req;
   logic signed [OFS_W-1:0] ofs;

   dly_trim_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .move   (move),
      .dir_dn (dir_dn),
      .req    (req)
   );

   dly_trim_offset #(.OFS_W(OFS_W)) u_ofs (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_n (load_n),
      .req    (req),
      .ofs    (ofs),
      .flag   (lim_flag)
   );

   dly_trim_sum #(.CODE_W(CODE_W), .OFS_W(OFS_W)) u_sum (
      .base (base_code),
      .ofs  (ofs),
      .code (trim_code)
   );

   // R2
   load_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> trim_code == base_code);

   // R8
   load_over_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && $fell(move)) |=> !lim_flag && trim_code == base_code);

endmodule

// File: tb/dly_trim_top_tb.sv
module dly_trim_top_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] base_code = 8'd128;
   logic       load_n = 1'b1;
   logic       move = 1'b0;
   logic       dir_dn = 1'b0;
   logic [7:0] trim_code;
   logic       lim_flag;

   int total = 0;
   int bad = 0;
   int ref_ofs = 0;
   int ref_flag = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dly_trim_top u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_code (base_code),
      .load_n    (load_n),
      .move      (move),
      .dir_dn    (dir_dn),
      .trim_code (trim_code),
      .lim_flag  (lim_flag)
   );

   function automatic int clampv(input int v);
      if (v < 0)   return 0;
      if (v > 255) return 255;
      return v;
   endfunction

   task automatic chk(input string req, input int got, input int exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%0d exp=%0d", req, got, exp);
      end
   endtask

   // One strobe: wrong direction while high, real direction as it falls.
   task automatic step(input bit d);
      @(negedge clk);
      move   = 1'b1;
      dir_dn = ~d;
      @(negedge clk);
      move   = 1'b0;
      dir_dn = d;
      @(negedge clk);
      if (!d) begin
         if (ref_ofs < 63) ref_ofs++;
         ref_flag = (ref_ofs == 63);
      end else begin
         if (ref_ofs > -64) ref_ofs--;
         ref_flag = (ref_ofs == -64);
      end
   endtask

   task automatic chk_state(input string req);
      chk({req, " code"}, int'(trim_code), clampv(int'(base_code) + ref_ofs));
      chk({req, " flag"}, int'(lim_flag), ref_flag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 reset code", int'(trim_code), 128);
      chk("R1 reset flag", int'(lim_flag), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release code", int'(trim_code), 128);

      // R3 move held high, then held low: no change
      move = 1'b1;
      repeat (4) @(negedge clk);
      chk("R3 held high", int'(trim_code), 128);
      move = 1'b0;
      @(negedge clk);
      ref_ofs = 1;
      chk("R3 single fall", int'(trim_code), 129);
      repeat (4) @(negedge clk);
      chk("R3 held low", int'(trim_code), 129);

      // R4 R5 R6 upward sweep into saturation
      for (int i = 0; i < 70; i++) begin
         step(1'b0);
         chk_state("R4 R5 R6 up");
      end
      chk("R5 max code", int'(trim_code), 191);
      chk("R6 flag at max", int'(lim_flag), 1);

      // R7 full base sweep at +63
      for (int b = 0; b < 256; b++) begin
         @(negedge clk);
         base_code = 8'(b);
         #1;
         chk("R7 clamp +63", int'(trim_code), clampv(b + 63));
      end
      @(negedge clk);
      base_code = 8'd128;

      // R6 opposite move clears the flag
      step(1'b1);
      chk("R6 opposite clears", int'(lim_flag), 0);
      chk("R4 down step", int'(trim_code), 190);

      // R4 R5 R6 downward sweep into saturation
      for (int i = 0; i < 130; i++) begin
         step(1'b1);
         chk_state("R4 R5 R6 down");
      end
      chk("R5 min code", int'(trim_code), 64);
      chk("R6 flag at min", int'(lim_flag), 1);

      // R7 full base sweep at -64
      for (int b = 0; b < 256; b++) begin
         @(negedge clk);
         base_code = 8'(b);
         #1;
         chk("R7 clamp -64", int'(trim_code), clampv(b - 64));
      end
      @(negedge clk);
      base_code = 8'd128;

      // R2 load returns offset to zero and clears the flag
      @(negedge clk);
      load_n = 1'b0;
      @(negedge clk);
      load_n = 1'b1;
      ref_ofs = 0;
      ref_flag = 0;
      chk("R2 load code", int'(trim_code), 128);
      chk("R2 load flag", int'(lim_flag), 0);
      base_code = 8'd37;
      #1;
      chk("R2 follows base", int'(trim_code), 37);
      base_code = 8'd128;

      // R8 load together with a detected fall
      for (int i = 0; i < 5; i++) step(1'b0);
      chk_state("R8 setup");
      @(negedge clk);
      move = 1'b1;
      dir_dn = 1'b0;
      @(negedge clk);
      move = 1'b0;
      load_n = 1'b0;
      @(negedge clk);
      load_n = 1'b1;
      ref_ofs = 0;
      ref_flag = 0;
      chk("R8 load wins code", int'(trim_code), 128);
      chk("R8 load wins flag", int'(lim_flag), 0);
      repeat (2) @(negedge clk);
      chk("R8 no late step", int'(trim_code), 128);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule